// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a supervision timer that keeps a processor in check. A 32-bit counter counts down toward zero from a value held in a programmable reload register. When it runs out for the first time, the block raises an interrupt and starts a new period. If software has still not acknowledged that interrupt when the next period also expires, the block escalates. It raises a reset request, but only when reset escalation is enabled. Once the reset request is asserted, it holds until the block itself is reset.

Software reaches the block through a simple word-wide register port: a write strobe, an address, write data and a combinational read-data bus. The port selects these registers:

- the reload value;
- the live count (read-only);
- a control word with a run/interrupt enable and a reset-escalation enable;
- an acknowledge address;
- a guard register.

Writing any value other than the unlock key to the guard register protects the reload and control registers against stray writes. Writing the key removes that protection. The acknowledge address stays usable at all times, so a protected watchdog can still be serviced. The asynchronous reset input is released through an internal synchroniser.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the interrupt and reset-request outputs are low. The reload register (address 0) and the live count (address 1) read all ones. The control register (address 2) and the guard register (address 4) read 0.
- R2: A write to address 0 while unprotected stores the value. The live count takes that value at the same clock edge, whether or not the counter is running.
- R3: Control bit 0 starts the counter. While it is 0 the count holds. While it is 1 the count falls by one per clock. A count of 0 is followed by a reload from the reload register.
- R4: The first expiry (the clock edge at which the count is 0 while running) sets the interrupt output.
- R5: An expiry while the interrupt is still pending sets the reset-request output if control bit 1 is 1.
- R6: An expiry while the interrupt is pending and control bit 1 is 0 leaves the reset-request output low. The interrupt stays high.
- R7: Any write to address 3 clears the interrupt and reloads the count from the reload register. The next escalation then needs two fresh expiries.
- R8: Writing a value other than the key 0x1ACCE55A to address 4 protects the block, and address 4 then reads 1. While protected, writes to addresses 0 and 2 change nothing. Writing the key unprotects the block, and address 4 then reads 0.
- R9: Once control bit 0 is set, writes cannot clear it. Control bit 1 can be written either way.
- R10: The reset-request output stays high until the block reset, even across interrupt acknowledges.
- R11: The acknowledge at address 3 works while the block is protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (shared by read and write) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | First-stage timeout interrupt |
| rst_req_o | output | 1 | Second-stage reset request (sticky) |

## Verification
A write takes effect at the rising edge that samples the strobe. Its result is visible on the read bus and the outputs at the next falling edge. The bench drives inputs and samples everything only at falling edges.

With reload value L and the counter started at edge 0, the count after n edges is L minus (n mod (L+1)). The interrupt is due at edge L+1 and the reset request at edge 2(L+1). The bench checks every cycle of that window arithmetically for several values of L, including L=0. After an acknowledge, the same counting restarts from the acknowledge edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD  = 3'd0,
    A_VALUE = 3'd1,
    A_CTRL  = 3'd2,
    A_CLEAR = 3'd3,
    A_LOCK  = 3'd4
  } wdog_addr_e;

  typedef struct packed {
    logic rst_en;
    logic int_en;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int                CNT_W      = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E55A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  load_o,
  output wdog_ctrl_t        ctrl_o,
  output logic              locked_o,
  output logic              force_o,
  output logic [CNT_W-1:0]  force_val_o,
  output logic              clear_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CNT_W-1:0] load_q, load_d;
  wdog_ctrl_t       ctrl_q, ctrl_d;
  logic             locked_q, locked_d;
  logic             load_en, ctrl_en, lock_en;
  logic             hit_load, hit_ctrl, hit_clear, hit_lock;

  always_comb begin
    hit_load  = we_i && (addr_i == A_LOAD);
    hit_ctrl  = we_i && (addr_i == A_CTRL);
    hit_clear = we_i && (addr_i == A_CLEAR);
    hit_lock  = we_i && (addr_i == A_LOCK);

    load_en = hit_load && !locked_q;
    load_d  = wdata_i[CNT_W-1:0];

    ctrl_en       = hit_ctrl && !locked_q;
    ctrl_d.int_en = ctrl_q.int_en | wdata_i[0];
    ctrl_d.rst_en = wdata_i[1];

    lock_en  = hit_lock;
    locked_d = (wdata_i != UNLOCK_KEY);

    clear_o     = hit_clear;
    force_o     = load_en | hit_clear;
    force_val_o = load_en ? load_d : load_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= '1;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (load_en) load_q   <= load_d;
      if (ctrl_en) ctrl_q   <= ctrl_d;
      if (lock_en) locked_q <= locked_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LOAD:  rdata_o[CNT_W-1:0] = load_q;
      A_VALUE: rdata_o[CNT_W-1:0] = cnt_i;
      A_CTRL:  rdata_o[1:0]       = {ctrl_q.rst_en, ctrl_q.int_en};
      A_LOCK:  rdata_o[0]         = locked_q;
      default: rdata_o            = '0;
    endcase
  end

  assign load_o   = load_q;
  assign ctrl_o   = ctrl_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] force_val_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    expire_o = run_i && !force_i && (cnt_q == '0);
    cnt_en   = force_i || run_i;
    if (force_i)       cnt_d = force_val_i;
    else if (expire_o) cnt_d = load_i;
    else               cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clear_i,
  input  logic rst_en_i,
  output logic irq_o,
  output logic rst_req_o
);
  logic irq_q, irq_d, irq_en;
  logic req_q, req_d, req_en;

  always_comb begin
    irq_en = clear_i || expire_i;
    irq_d  = !clear_i;
    req_en = expire_i && irq_q && !clear_i && rst_en_i;
    req_d  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (irq_en) irq_q <= irq_d;
      if (req_en) req_q <= req_d;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int                CNT_W       = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 32'h1ACC_E55A,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] force_val;
  wdog_ctrl_t       ctrl;
  logic             locked;
  logic             force_ld;
  logic             clear;
  logic             expire;
  logic             irq;
  logic             rst_req;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  wdog_regs #(.CNT_W(CNT_W), .UNLOCK_KEY(UNLOCK_KEY)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .cnt_i       (cnt),
    .load_o      (load_val),
    .ctrl_o      (ctrl),
    .locked_o    (locked),
    .force_o     (force_ld),
    .force_val_o (force_val),
    .clear_o     (clear),
    .rdata_o     (reg_rdata_o)
  );

  wdog_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .run_i       (ctrl.int_en),
    .force_i     (force_ld),
    .force_val_i (force_val),
    .load_i      (load_val),
    .cnt_o       (cnt),
    .expire_o    (expire)
  );

  wdog_escalate i_escalate (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .expire_i  (expire),
    .clear_i   (clear),
    .rst_en_i  (ctrl.rst_en),
    .irq_o     (irq),
    .rst_req_o (rst_req)
  );

  assign irq_o     = irq;
  assign rst_req_o = rst_req;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq,
  input logic              rst_req,
  input logic              int_en,
  input logic              locked,
  input logic [CNT_W-1:0]  load_val,
  input logic [CNT_W-1:0]  cnt
);
  AST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_req |=> rst_req); // R10

  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    int_en |=> int_en); // R9

  AST_REQ_AFTER_IRQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_req) |-> $past(irq)); // R5

  AST_LOCKED_LOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (locked && we_i && addr_i == A_LOAD) |=> $stable(load_val)); // R8

  AST_ACK_CLEARS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    (we_i && addr_i == A_CLEAR) |=> !irq); // R7

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!int_en && !(we_i && (addr_i == A_LOAD || addr_i == A_CLEAR))) |=> $stable(cnt)); // R3
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_sync_n),
  .we_i     (reg_we_i),
  .addr_i   (reg_addr_i),
  .irq      (irq),
  .rst_req  (rst_req),
  .int_en   (ctrl.int_en),
  .locked   (locked),
  .load_val (load_val),
  .cnt      (cnt)
);

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
  import wdog_pkg::*;

  localparam logic [31:0] KEY = 32'h1ACC_E55A;

  logic        clk;
  logic        rst_n;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        rreq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  wdog_two_stage #(.CNT_W(32), .UNLOCK_KEY(KEY)) i_wdog_two_stage (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .rst_req_o   (rreq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_reset();
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b1;
    do_reset();

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rst_req", {31'b0, rreq}, 0);
    rd(A_LOAD, v);  chk("R1 load", v, 32'hFFFF_FFFF);
    rd(A_VALUE, v); chk("R1 value", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_LOCK, v);  chk("R1 lock", v, 0);

    // R2 load write reloads at once; R3 no counting while stopped
    wr(A_LOAD, 10);
    rd(A_VALUE, v); chk("R2 value after load", v, 10);
    step(5);
    rd(A_VALUE, v); chk("R3 hold while stopped", v, 10);

    // R3/R4/R5 sweep over reload values
    for (int L = 0; L < 7; L++) begin
      do_reset();
      wr(A_LOAD, L);
      wr(A_CTRL, 3);
      for (int n = 0; n <= 2 * (L + 1) + 2; n++) begin
        if (n > 0) @(negedge clk);
        rd(A_VALUE, v);
        chk("R3 count", v, L - (n % (L + 1)));
        chk("R4 irq", {31'b0, irq}, (n >= L + 1) ? 1 : 0);
        chk("R5 rst_req", {31'b0, rreq}, (n >= 2 * (L + 1)) ? 1 : 0);
      end
      // R10 acknowledge does not drop the reset request
      wr(A_CLEAR, 0);
      chk("R10 irq cleared", {31'b0, irq}, 0);
      chk("R10 rst_req held", {31'b0, rreq}, 1);
      step(3);
      chk("R10 rst_req still held", {31'b0, rreq}, 1);
    end

    // R2 load write while running
    do_reset();
    wr(A_LOAD, 20);
    wr(A_CTRL, 1);
    step(4);
    wr(A_LOAD, 9);
    rd(A_VALUE, v); chk("R2 reload while running", v, 9);
    step(2);
    rd(A_VALUE, v); chk("R2 count from new value", v, 7);

    // R6 no reset request when escalation disabled
    do_reset();
    wr(A_LOAD, 3);
    wr(A_CTRL, 1);
    step(3 * 4 + 1);
    chk("R6 irq high", {31'b0, irq}, 1);
    chk("R6 rst_req low", {31'b0, rreq}, 0);

    // R7 acknowledge reloads and restarts escalation
    do_reset();
    wr(A_LOAD, 4);
    wr(A_CTRL, 3);
    step(7);
    chk("R7 irq before ack", {31'b0, irq}, 1);
    wr(A_CLEAR, 32'hDEAD);
    rd(A_VALUE, v); chk("R7 reload on ack", v, 4);
    chk("R7 irq cleared", {31'b0, irq}, 0);
    step(4);
    chk("R7 irq still low", {31'b0, irq}, 0);
    step(1);
    chk("R7 irq again", {31'b0, irq}, 1);
    chk("R7 no early rst_req", {31'b0, rreq}, 0);
    step(4);
    chk("R7 rst_req not yet", {31'b0, rreq}, 0);
    step(1);
    chk("R7 rst_req on second expiry", {31'b0, rreq}, 1);

    // R8 guard register
    do_reset();
    wr(A_LOAD, 7);
    wr(A_LOCK, 0);
    rd(A_LOCK, v); chk("R8 locked reads 1", v, 1);
    wr(A_LOAD, 20);
    rd(A_LOAD, v);  chk("R8 load ignored", v, 7);
    rd(A_VALUE, v); chk("R8 value unchanged", v, 7);
    wr(A_CTRL, 3);
    rd(A_CTRL, v);  chk("R8 ctrl ignored", v, 0);
    step(3);
    rd(A_VALUE, v); chk("R8 still stopped", v, 7);
    wr(A_LOCK, KEY ^ 32'h1);
    rd(A_LOCK, v); chk("R8 near-key locks", v, 1);
    wr(A_LOCK, KEY);
    rd(A_LOCK, v); chk("R8 key unlocks", v, 0);
    wr(A_LOAD, 20);
    rd(A_LOAD, v); chk("R8 load after unlock", v, 20);

    // R11 acknowledge while protected
    do_reset();
    wr(A_LOAD, 2);
    wr(A_CTRL, 1);
    step(3);
    chk("R11 irq set", {31'b0, irq}, 1);
    wr(A_LOCK, 32'h0BAD);
    wr(A_CLEAR, 0);
    chk("R11 irq cleared while locked", {31'b0, irq}, 0);
    rd(A_VALUE, v); chk("R11 reload while locked", v, 2);

    // R9 run enable sticky, escalation enable writable
    do_reset();
    wr(A_LOAD, 100);
    wr(A_CTRL, 1);
    wr(A_CTRL, 0);
    rd(A_CTRL, v); chk("R9 run bit sticky", v, 1);
    wr(A_CTRL, 2);
    rd(A_CTRL, v); chk("R9 escalation set", v, 3);
    wr(A_CTRL, 0);
    rd(A_CTRL, v); chk("R9 escalation cleared", v, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule